// File: doc/BRIEF.md
# Integration Timing Controller

This block paces the integration cycles of one or more charge-integrating converters. It runs from a 16 MHz master clock and divides it into a 2 MHz system clock and a data-transfer clock. The data-transfer clock runs at 1, 2, 4 or 8 MHz. At the start of every integration cycle it drives a cycle strobe that is one system clock wide. Cycles either repeat back to back with a programmable length, or each one is launched by an external trigger.

After every strobe the block holds readout off for a programmable transmit delay, counted in system clocks. Because correlated double sampling needs the acquisition and sampling phases to finish first, the delay actually used is never shorter than the sum of those two counts. When the delay has run out, the block raises a transmit window for 24 data clocks per configured device. The window then stays low until the next cycle.

Top module: `integ_timing_ctrl`

## Requirements
- R1: `sys_clk` is the master clock divided by 8 with 50 % duty. It is low for the first 4 master clocks after reset is released.
- R2: `data_clk` is the master clock divided by 16, 8, 4 or 2 for `cfg_rate_sel` values 0, 1, 2 and 3. Its phase is taken from the same reset-aligned counter, so it is low for the first half period after reset.
- R3: In continuous mode (`cfg_trig_mode`=0), `cycle_strobe` first rises 8 master clocks after reset is released. It then rises every L system clocks (8·L master clocks), where L is `cfg_cycle_len`.
- R4: `cycle_strobe` is high for exactly one system clock (8 master clocks) per cycle.
- R5: A `cfg_cycle_len` of 0 or 1 is treated as 2.
- R6: In triggered mode (`cfg_trig_mode`=1), no strobe occurs without a trigger. A trigger sampled high at a master clock edge starts a cycle at the first system-clock boundary after that edge. The strobe rises at the next master count that is a multiple of 8.
- R7: A trigger that arrives while a triggered cycle is active is discarded, not queued. This includes a trigger in the cycle's final system clock.
- R8: `xmit_en` rises D system clocks after the strobe rises, where D is the effective delay. At a 1 MHz data rate it waits a further half data period when needed, so that it rises where `data_clk` falls.
- R9: With an effective delay of 0, `xmit_en` rises together with the strobe, subject to the same data-clock alignment.
- R10: `xmit_en` stays high for exactly 24·N data-clock periods, where N is the device count. It then stays low until the next cycle.
- R11: The effective delay is the larger of `cfg_xmit_delay` and `cfg_acq_cnt + cfg_smp_cnt`.
- R12: A `cfg_num_dev` of 0 is treated as one device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_trig_mode | input | 1 | 0 = continuous cycles, 1 = externally triggered |
| cfg_cycle_len | input | CYC_W | Cycle length in system clocks |
| cfg_rate_sel | input | 2 | Data clock rate: 0=1 MHz, 1=2 MHz, 2=4 MHz, 3=8 MHz |
| cfg_xmit_delay | input | DLY_W | Requested transmit delay in system clocks |
| cfg_acq_cnt | input | CNT_W | Acquisition count in system clocks |
| cfg_smp_cnt | input | CNT_W | Sample-per-integration count in system clocks |
| cfg_num_dev | input | NDEV_W | Number of converters read per cycle |
| ext_trig | input | 1 | External cycle trigger |
| sys_clk | output | 1 | 2 MHz system clock |
| data_clk | output | 1 | Selected data-transfer clock |
| cycle_strobe | output | 1 | Integration-cycle start strobe |
| xmit_en | output | 1 | Result transfer window |

## Verification
The bench targets these failure modes:
- Phase of the delay and window against the data clock. At 1 MHz, half the delay expiries fall in the middle of a data period. A design that skips the alignment opens a window half a period early and cuts it short.
- The transmit-delay floor. A requested delay of 2 with acquisition and sample counts of 16 and 32 must still wait 48 system clocks. A design that ignores the floor opens the window 46 system clocks early.
- Cycle-length clamping and device-count clamping. A zero length would freeze or stretch the strobe. A zero device count would give an empty or wrapped window.
- Triggers in the middle of a cycle and in the final system clock. A design that queues these triggers, or ends the active phase one clock early, launches a stray cycle.

// File: rtl/itc_pkg.sv
package itc_pkg;

    // System clock = master / 2**SYS_DIV_LOG2
    localparam int SYS_DIV_LOG2 = 3;
    // Data clock rates: master / 2**(NUM_RATES - sel)
    localparam int NUM_RATES    = 4;
    localparam int SEL_W        = $clog2(NUM_RATES);
    localparam int WORD_BITS    = 24;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_WAIT = 2'd1,
        XS_SEND = 2'd2
    } xmit_state_e;

    typedef struct packed {
        logic sys;        // system clock level
        logic sys_tick;   // last master cycle of a system period
        logic data;       // data clock level
        logic data_tick;  // last master cycle of a data period
    } clk_bus_t;

    function automatic logic [31:0] floor_at(input logic [31:0] v, input logic [31:0] lo);
        return (v < lo) ? lo : v;
    endfunction

endpackage

// File: rtl/itc_clkgen.sv
module itc_clkgen
    import itc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] rate_sel,
    output clk_bus_t         ck
);

    logic [NUM_RATES-1:0] div_q;
    logic [NUM_RATES-1:0] rate_lvl;
    logic [NUM_RATES-1:0] rate_end;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + 1'b1;
    end

    // one rate per select code, slowest first
    for (genvar g = 0; g < NUM_RATES; g++) begin : g_rate
        assign rate_lvl[g] = div_q[NUM_RATES-1-g];
        assign rate_end[g] = &div_q[NUM_RATES-1-g:0];
    end

    always_comb begin
        ck.sys       = div_q[SYS_DIV_LOG2-1];
        ck.sys_tick  = &div_q[SYS_DIV_LOG2-1:0];
        ck.data      = rate_lvl[rate_sel];
        ck.data_tick = rate_end[rate_sel];
    end

    AST_SYS_FALLS_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        ck.sys_tick |=> (!ck.sys && $past(ck.sys))); // R1

    AST_DATA_FALLS_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        (ck.data_tick && $stable(rate_sel)) |=> ($stable(rate_sel) -> !ck.data)); // R2

endmodule

// File: rtl/itc_cycle.sv
module itc_cycle
    import itc_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sys_tick,
    input  logic             trig_mode,
    input  logic [CYC_W-1:0] cyc_len,
    input  logic             ext_trig,
    output logic             strobe,
    output logic             cyc_start
);

    logic             active_q;
    logic             pend_q;
    logic             strobe_q;
    logic [CYC_W-1:0] cnt_q;
    logic [CYC_W-1:0] len_eff;
    logic             last_sys;
    logic             want;
    logic             cyc_done;

    always_comb begin
        len_eff   = CYC_W'(floor_at(32'(cyc_len), 32'd2));
        last_sys  = (cnt_q == len_eff - 1'b1);
        cyc_done  = active_q && last_sys;
        want      = !trig_mode || pend_q || ext_trig;
        cyc_start = sys_tick && ((!active_q && want) || (cyc_done && !trig_mode));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            pend_q   <= 1'b0;
            strobe_q <= 1'b0;
            cnt_q    <= '0;
        end else begin
            // a trigger is only remembered while no cycle is active
            if (cyc_start)                 pend_q <= 1'b0;
            else if (ext_trig && !active_q) pend_q <= 1'b1;

            if (sys_tick) begin
                strobe_q <= cyc_start;
                if (cyc_start) begin
                    active_q <= 1'b1;
                    cnt_q    <= '0;
                end else if (active_q) begin
                    if (last_sys) active_q <= 1'b0;
                    else          cnt_q    <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign strobe = strobe_q;

    AST_STROBE_ONLY_ON_SYS_EDGE: assert property (@(posedge clk) disable iff (rst)
        !$past(sys_tick) |-> $stable(strobe_q)); // R4

    AST_STROBE_ONE_SYS_WIDE: assert property (@(posedge clk) disable iff (rst)
        (sys_tick && strobe_q) |=> !strobe_q); // R4

    AST_TRIG_NEEDED: assert property (@(posedge clk) disable iff (rst)
        ($rose(strobe_q) && trig_mode && $past(trig_mode)) |-> $past(pend_q || ext_trig)); // R6

    AST_NO_RESTART_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (trig_mode && active_q && sys_tick) |=> !strobe_q); // R7

endmodule

// File: rtl/itc_xmit.sv
module itc_xmit
    import itc_pkg::*;
#(
    parameter int DLY_W  = 16,
    parameter int CNT_W  = 8,
    parameter int NDEV_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sys_tick,
    input  logic              data_tick,
    input  logic              cyc_start,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic [CNT_W-1:0]  cfg_acq,
    input  logic [CNT_W-1:0]  cfg_smp,
    input  logic [NDEV_W-1:0] cfg_ndev,
    output logic              xmit_en
);

    localparam int SUM_W = CNT_W + 1;
    localparam int EFF_W = (DLY_W > SUM_W) ? DLY_W : SUM_W;
    localparam int WIN_W = NDEV_W + $clog2(WORD_BITS);

    xmit_state_e      state_q;
    logic [EFF_W-1:0] rem_q;
    logic [WIN_W-1:0] bit_q;
    logic [SUM_W-1:0] floor_cnt;
    logic [EFF_W-1:0] eff_delay;
    logic [WIN_W-1:0] total;
    logic             expire;

    always_comb begin
        floor_cnt = SUM_W'(cfg_acq) + SUM_W'(cfg_smp);
        eff_delay = (EFF_W'(cfg_delay) > EFF_W'(floor_cnt)) ? EFF_W'(cfg_delay) : EFF_W'(floor_cnt);
        total     = WIN_W'(floor_at(32'(cfg_ndev), 32'd1)) * WIN_W'(WORD_BITS);
        expire    = (rem_q == '0) || (sys_tick && rem_q == EFF_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= XS_IDLE;
            rem_q   <= '0;
            bit_q   <= '0;
        end else if (cyc_start) begin
            bit_q <= '0;
            rem_q <= eff_delay;
            state_q <= (eff_delay == '0 && data_tick) ? XS_SEND : XS_WAIT;
        end else begin
            unique case (state_q)
                XS_WAIT: begin
                    if (expire && data_tick) begin
                        state_q <= XS_SEND;
                        bit_q   <= '0;
                    end else if (sys_tick && rem_q != '0) begin
                        rem_q <= rem_q - 1'b1;
                    end
                end
                XS_SEND: begin
                    if (data_tick) begin
                        if (bit_q == total - 1'b1) state_q <= XS_IDLE;
                        else                       bit_q   <= bit_q + 1'b1;
                    end
                end
                default: state_q <= XS_IDLE;
            endcase
        end
    end

    assign xmit_en = (state_q == XS_SEND);

    AST_XMIT_ON_DATA_EDGE: assert property (@(posedge clk) disable iff (rst)
        $rose(xmit_en) |-> ($past(data_tick) || $past(cyc_start))); // R8

    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == XS_SEND) |-> (bit_q < total)); // R10

    AST_WAIT_NOT_ABOVE_DELAY: assert property (@(posedge clk) disable iff (rst)
        ((state_q == XS_WAIT) && $stable(eff_delay)) |-> (rem_q <= eff_delay)); // R11

endmodule

// File: rtl/integ_timing_ctrl.sv
module integ_timing_ctrl
    import itc_pkg::*;
#(
    parameter int CYC_W  = 16,
    parameter int DLY_W  = 16,
    parameter int CNT_W  = 8,
    parameter int NDEV_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_trig_mode,
    input  logic [CYC_W-1:0]  cfg_cycle_len,
    input  logic [1:0]        cfg_rate_sel,
    input  logic [DLY_W-1:0]  cfg_xmit_delay,
    input  logic [CNT_W-1:0]  cfg_acq_cnt,
    input  logic [CNT_W-1:0]  cfg_smp_cnt,
    input  logic [NDEV_W-1:0] cfg_num_dev,
    input  logic              ext_trig,
    output logic              sys_clk,
    output logic              data_clk,
    output logic              cycle_strobe,
    output logic              xmit_en
);

    clk_bus_t ck;
    logic     cyc_start;

    itc_clkgen u_clkgen (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (SEL_W'(cfg_rate_sel)),
        .ck       (ck)
    );

    itc_cycle #(.CYC_W(CYC_W)) u_cycle (
        .clk       (clk),
        .rst       (rst),
        .sys_tick  (ck.sys_tick),
        .trig_mode (cfg_trig_mode),
        .cyc_len   (cfg_cycle_len),
        .ext_trig  (ext_trig),
        .strobe    (cycle_strobe),
        .cyc_start (cyc_start)
    );

    itc_xmit #(.DLY_W(DLY_W), .CNT_W(CNT_W), .NDEV_W(NDEV_W)) u_xmit (
        .clk       (clk),
        .rst       (rst),
        .sys_tick  (ck.sys_tick),
        .data_tick (ck.data_tick),
        .cyc_start (cyc_start),
        .cfg_delay (cfg_xmit_delay),
        .cfg_acq   (cfg_acq_cnt),
        .cfg_smp   (cfg_smp_cnt),
        .cfg_ndev  (cfg_num_dev),
        .xmit_en   (xmit_en)
    );

    assign sys_clk  = ck.sys;
    assign data_clk = ck.data;

    AST_STROBE_STARTS_LOW_SYS: assert property (@(posedge clk) disable iff (rst)
        $rose(cycle_strobe) |-> !sys_clk); // R3

endmodule

// File: tb/test_integ_timing_ctrl.sv
`timescale 1ns/1ps
module test_integ_timing_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_trig_mode = 1'b0;
    logic [15:0] cfg_cycle_len = 16'd20;
    logic [1:0]  cfg_rate_sel = 2'd0;
    logic [15:0] cfg_xmit_delay = '0;
    logic [7:0]  cfg_acq_cnt = '0;
    logic [7:0]  cfg_smp_cnt = '0;
    logic [5:0]  cfg_num_dev = 6'd1;
    logic        ext_trig = 1'b0;
    logic        sys_clk, data_clk, cycle_strobe, xmit_en;

    int n_chk = 0;
    int n_err = 0;
    int k = 0;          // master clocks since reset release
    bit done = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) k <= 0;
        else     k <= k + 1;
    end

    integ_timing_ctrl i_integ_timing_ctrl (
        .clk(clk), .rst(rst), .cfg_trig_mode(cfg_trig_mode), .cfg_cycle_len(cfg_cycle_len),
        .cfg_rate_sel(cfg_rate_sel), .cfg_xmit_delay(cfg_xmit_delay), .cfg_acq_cnt(cfg_acq_cnt),
        .cfg_smp_cnt(cfg_smp_cnt), .cfg_num_dev(cfg_num_dev), .ext_trig(ext_trig),
        .sys_clk(sys_clk), .data_clk(data_clk), .cycle_strobe(cycle_strobe), .xmit_en(xmit_en)
    );

    task automatic chk(input string rq, input string what, input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s %s at k=%0d: got %0b expected %0b", rq, what, k, got, exp);
        end
    endtask

    function automatic bit exp_xmit(input int kk, input int s, input int deff, input int sel, input int neff);
        int r;
        if (s < 0) return 0;
        r = s + 8 * deff;
        if (sel == 0 && (r % 16) != 0) r += 8;
        return (kk >= r) && (kk < r + 24 * neff * (16 >> sel));
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1", "sys_clk in reset", sys_clk, 1'b0);
        chk("R3", "strobe in reset", cycle_strobe, 1'b0);
        chk("R10", "xmit_en in reset", xmit_en, 1'b0);
        rst = 1'b0;
    endtask

    task automatic check_clocks(input int sel);
        chk("R1", "sys_clk", sys_clk, 1'((k >> 2) & 1));
        chk("R2", "data_clk", data_clk, 1'((k >> (3 - sel)) & 1));
    endtask

    // continuous mode sweep point; len < 0 picks a length that fits the window
    task automatic run_cont(input int sel, input int n, input int d, input int a, input int s,
                            input int len, input bit chk_x, input string rq);
        int deff = (d > a + s) ? d : a + s;
        int neff = (n == 0) ? 1 : n;
        int p    = 16 >> sel;
        int lreq = (len < 0) ? deff + 3 * neff * p + 2 : len;
        int leff = (lreq < 2) ? 2 : lreq;
        int st;
        cfg_trig_mode  = 1'b0;
        cfg_rate_sel   = 2'(sel);
        cfg_num_dev    = 6'(n);
        cfg_xmit_delay = 16'(d);
        cfg_acq_cnt    = 8'(a);
        cfg_smp_cnt    = 8'(s);
        cfg_cycle_len  = 16'(lreq);
        do_reset();
        repeat (8 + 16 * 8 * leff / 8 + 40) begin
            @(negedge clk);
            st = (k < 8) ? -1 : 8 + ((k - 8) / (8 * leff)) * (8 * leff);
            check_clocks(sel);
            chk((len >= 0 && len < 2) ? "R5" : "R3 R4", "cycle_strobe",
                cycle_strobe, (st >= 0) && (k - st < 8));
            if (chk_x) chk(rq, "xmit_en", xmit_en, exp_xmit(k, st, deff, sel, neff));
        end
    endtask

    task automatic pulse_trig(input int c);
        while (k != c) @(negedge clk);
        ext_trig = 1'b1;
        @(negedge clk);
        ext_trig = 1'b0;
    endtask

    task automatic run_trig();
        int st;
        cfg_trig_mode  = 1'b1;
        cfg_rate_sel   = 2'd3;
        cfg_num_dev    = 6'd1;
        cfg_xmit_delay = 16'd4;
        cfg_acq_cnt    = '0;
        cfg_smp_cnt    = '0;
        cfg_cycle_len  = 16'd20;
        do_reset();
        fork
            begin
                // 30 -> start 32; 72 and 191 fall inside the active cycle; 192 -> 200; 375 -> 376
                pulse_trig(30);
                pulse_trig(72);
                pulse_trig(191);
                pulse_trig(192);
                pulse_trig(375);
            end
            begin
                repeat (600) begin
                    @(negedge clk);
                    st = (k >= 376) ? 376 : (k >= 200) ? 200 : (k >= 32) ? 32 : -1;
                    check_clocks(3);
                    chk((k < 32) ? "R6" : "R6 R7", "cycle_strobe", cycle_strobe,
                        (st >= 0) && (k - st < 8));
                    chk("R7 R8", "xmit_en", xmit_en, exp_xmit(k, st, 4, 3, 1));
                end
            end
        join
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int sel = 0; sel < 4; sel++) begin
            run_cont(sel, 1, 0, 0, 0, -1, 1'b1, "R9 R10");
            run_cont(sel, 2, 6, 2, 3, -1, 1'b1, "R8 R10");
            run_cont(sel, 0, 2, 16, 32, -1, 1'b1, "R11 R12");
        end
        run_cont(3, 1, 0, 0, 0, 0, 1'b0, "R5");
        run_cont(2, 1, 0, 0, 0, 1, 1'b0, "R5");
        run_trig();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule